// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one decoded instruction into the addresses its execution needs. Each cycle it may take an addressing class, up to three operand bytes, a flag for whether the instruction carries a leading prefix byte, a selector for the second index register, the two index register values and the address of the instruction's first byte. From these it forms the 16-bit data address and, for branch forms, the 16-bit branch destination. Results are registered and appear one clock after the input strobe, with their own valid strobe.

Relative destinations are measured from the byte just past the signed offset, so the base depends on the prefix and on how many operand bytes precede the offset. Bit-test branches carry a data address and a branch offset together, and both results come out in the same cycle. Index offsets are treated as unsigned. All address sums wrap at 16 bits.

Top module: `opnd_ea_gen`

## Requirements
- R1: Class code 2 (page-zero) gives a data address whose high byte is 0x00 and whose low byte is operand byte 0, with the address-valid flag set and the target-valid flag clear.
- R2: Class code 3 (absolute) gives a data address of operand byte 0 as the high byte and operand byte 1 as the low byte, with the address-valid flag set.
- R3: Class code 4 (indexed) with the index select low gives X plus operand byte 0, zero-extended, so offsets 0x80 to 0xFF add 128 to 255.
- R4: With the index select high, the indexed classes (codes 4 and 7) add the unsigned offset to Y in place of X.
- R5: Class code 5 (relative) gives a target of start address + 2 + sign-extended operand byte 0, with the target-valid flag set and the address-valid flag clear.
- R6: Class codes 6 (page-zero bit branch) and 7 (indexed bit branch) give, in the same output cycle, the data address from operand byte 0 as in R1 or R3/R4 and a target of start address + 4 + sign-extended operand byte 2, operand byte 1 being the mask; both valid flags are set.
- R7: A set prefix flag adds one to the relative base of every branch class.
- R8: Every 16-bit sum wraps modulo 65536 without any indication.
- R9: Class codes 0 (inherent) and 1 (immediate) give zero on both address outputs with both valid flags clear.
- R10: The output strobe follows the input strobe by exactly one clock; with the input strobe low, the address outputs and flags keep their last values.
- R11: While reset is asserted, the output strobe, both addresses and both valid flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input strobe |
| amode_i | input | 3 | Addressing class code |
| pfx_i | input | 1 | Instruction carries a prefix byte |
| idx_y_i | input | 1 | Index with Y instead of X |
| op0_i | input | 8 | First operand byte |
| op1_i | input | 8 | Second operand byte |
| op2_i | input | 8 | Third operand byte |
| pc_i | input | 16 | Address of the instruction's first byte |
| ix_i | input | 16 | X index register |
| iy_i | input | 16 | Y index register |
| valid_o | output | 1 | Output strobe |
| ea_o | output | 16 | Data effective address |
| ea_vld_o | output | 1 | Data address is meaningful |
| tgt_o | output | 16 | Branch target address |
| tgt_vld_o | output | 1 | Branch target is meaningful |

## Verification
Every result of this block is due on the first rising edge after the edge that captured the input strobe, so the bench drives each vector on a falling edge and checks the outputs on the next falling edge, while the following vector is already applied. This keeps the stream back to back and tests that each result belongs to its own input rather than a neighbour's. The hold behaviour is checked one falling edge after a cycle with the strobe low and changed inputs, and the reset state is read before the first strobe.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    AM_INH    = 3'd0,
    AM_IMM    = 3'd1,
    AM_DIR    = 3'd2,
    AM_EXT    = 3'd3,
    AM_IDX    = 3'd4,
    AM_REL    = 3'd5,
    AM_DIR_BR = 3'd6,
    AM_IDX_BR = 3'd7
  } amode_e;

  function automatic logic is_branch(amode_e m);
    return (m == AM_REL) || (m == AM_DIR_BR) || (m == AM_IDX_BR);
  endfunction

  function automatic logic has_data_addr(amode_e m);
    return (m == AM_DIR) || (m == AM_EXT) || (m == AM_IDX) ||
           (m == AM_DIR_BR) || (m == AM_IDX_BR);
  endfunction
endpackage

// File: rtl/opnd_ea_len.sv
module opnd_ea_len
  import opnd_ea_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BYTE_W
) (
  input  amode_e          amode_i,
  input  logic            pfx_i,
  input  logic [AW-1:0]   pc_i,
  output logic [AW-1:0]   next_pc_o
);
  localparam int unsigned LEN_W = 3;

  logic [LEN_W-1:0] opnd_cnt;
  logic [LEN_W-1:0] inst_len;

  always_comb begin
    unique case (amode_i)
      AM_DIR, AM_IDX, AM_REL: opnd_cnt = LEN_W'(1);
      AM_EXT:                 opnd_cnt = LEN_W'(2);
      AM_DIR_BR, AM_IDX_BR:   opnd_cnt = LEN_W'(3);
      default:                opnd_cnt = '0;
    endcase
  end

  // prefix + opcode + operands
  assign inst_len  = opnd_cnt + LEN_W'(1) + LEN_W'(pfx_i);
  assign next_pc_o = pc_i + AW'(inst_len);
endmodule

// File: rtl/opnd_ea_data.sv
module opnd_ea_data
  import opnd_ea_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BYTE_W
) (
  input  amode_e          amode_i,
  input  logic            idx_y_i,
  input  logic [BW-1:0]   op0_i,
  input  logic [BW-1:0]   op1_i,
  input  logic [AW-1:0]   ix_i,
  input  logic [AW-1:0]   iy_i,
  output logic [AW-1:0]   ea_o,
  output logic            ea_vld_o
);
  localparam int unsigned HI_W = AW - BW;

  logic [AW-1:0] idx_base;
  logic [AW-1:0] idx_sum;
  logic [AW-1:0] page0;
  logic [AW-1:0] absol;

  assign idx_base = idx_y_i ? iy_i : ix_i;
  assign idx_sum  = idx_base + {{HI_W{1'b0}}, op0_i};
  assign page0    = {{HI_W{1'b0}}, op0_i};
  assign absol    = AW'({op0_i, op1_i});

  always_comb begin
    unique case (amode_i)
      AM_DIR, AM_DIR_BR: ea_o = page0;
      AM_EXT:            ea_o = absol;
      AM_IDX, AM_IDX_BR: ea_o = idx_sum;
      default:           ea_o = '0;
    endcase
  end

  assign ea_vld_o = has_data_addr(amode_i);
endmodule

// File: rtl/opnd_ea_tgt.sv
module opnd_ea_tgt
  import opnd_ea_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BYTE_W
) (
  input  amode_e          amode_i,
  input  logic [BW-1:0]   op0_i,
  input  logic [BW-1:0]   op2_i,
  input  logic [AW-1:0]   base_i,
  output logic [AW-1:0]   tgt_o,
  output logic            tgt_vld_o
);
  localparam int unsigned EXT_W = AW - BW;

  logic [BW-1:0] rel_off;
  logic [AW-1:0] rel_sext;
  logic          br;

  assign br       = is_branch(amode_i);
  // bit-branch forms carry the offset after address and mask
  assign rel_off  = (amode_i == AM_REL) ? op0_i : op2_i;
  assign rel_sext = {{EXT_W{rel_off[BW-1]}}, rel_off};
  assign tgt_o    = br ? (base_i + rel_sext) : '0;
  assign tgt_vld_o = br;
endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
  import opnd_ea_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    amode_i,
  input  logic          pfx_i,
  input  logic          idx_y_i,
  input  logic [BW-1:0] op0_i,
  input  logic [BW-1:0] op1_i,
  input  logic [BW-1:0] op2_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] ix_i,
  input  logic [AW-1:0] iy_i,
  output logic          valid_o,
  output logic [AW-1:0] ea_o,
  output logic          ea_vld_o,
  output logic [AW-1:0] tgt_o,
  output logic          tgt_vld_o
);
  amode_e        mode;
  logic [AW-1:0] base_d;
  logic [AW-1:0] ea_d;
  logic          ea_vld_d;
  logic [AW-1:0] tgt_d;
  logic          tgt_vld_d;

  assign mode = amode_e'(amode_i);

  opnd_ea_len #(.AW(AW), .BW(BW)) u_len (
    .amode_i   (mode),
    .pfx_i     (pfx_i),
    .pc_i      (pc_i),
    .next_pc_o (base_d)
  );

  opnd_ea_data #(.AW(AW), .BW(BW)) u_data (
    .amode_i  (mode),
    .idx_y_i  (idx_y_i),
    .op0_i    (op0_i),
    .op1_i    (op1_i),
    .ix_i     (ix_i),
    .iy_i     (iy_i),
    .ea_o     (ea_d),
    .ea_vld_o (ea_vld_d)
  );

  opnd_ea_tgt #(.AW(AW), .BW(BW)) u_tgt (
    .amode_i   (mode),
    .op0_i     (op0_i),
    .op2_i     (op2_i),
    .base_i    (base_d),
    .tgt_o     (tgt_d),
    .tgt_vld_o (tgt_vld_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_o      <= '0;
      ea_vld_o  <= 1'b0;
      tgt_o     <= '0;
      tgt_vld_o <= 1'b0;
    end else if (valid_i) begin
      ea_o      <= ea_d;
      ea_vld_o  <= ea_vld_d;
      tgt_o     <= tgt_d;
      tgt_vld_o <= tgt_vld_d;
    end
  end
endmodule

// File: rtl/opnd_ea_gen_chk.sv
module opnd_ea_gen_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned BW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [2:0]    amode_i,
  input logic          idx_y_i,
  input logic [BW-1:0] op0_i,
  input logic [BW-1:0] op1_i,
  input logic [AW-1:0] ix_i,
  input logic [AW-1:0] iy_i,
  input logic          valid_o,
  input logic [AW-1:0] ea_o,
  input logic          ea_vld_o,
  input logic [AW-1:0] tgt_o,
  input logic          tgt_vld_o
);
  // R1
  page0_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amode_i == 3'd2) |=>
      (ea_o == {{(AW-BW){1'b0}}, $past(op0_i)} && ea_vld_o && !tgt_vld_o));

  // R2
  absolute_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amode_i == 3'd3) |=>
      (ea_o == AW'({$past(op0_i), $past(op1_i)}) && ea_vld_o));

  // R3
  index_x_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amode_i == 3'd4 && !idx_y_i) |=>
      (ea_o == AW'($past(ix_i) + AW'($past(op0_i)))));

  // R4
  index_y_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amode_i == 3'd4 && idx_y_i) |=>
      (ea_o == AW'($past(iy_i) + AW'($past(op0_i)))));

  // R6
  bit_branch_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amode_i[2:1] == 2'b11) |=> (ea_vld_o && tgt_vld_o));

  // R9
  no_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amode_i[2:1] == 2'b00) |=>
      (!ea_vld_o && !tgt_vld_o && ea_o == '0 && tgt_o == '0));

  // R10
  strobe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R10
  strobe_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(ea_o) && $stable(tgt_o) && $stable(ea_vld_o) && $stable(tgt_vld_o)));
endmodule

bind opnd_ea_gen opnd_ea_gen_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .amode_i   (amode_i),
  .idx_y_i   (idx_y_i),
  .op0_i     (op0_i),
  .op1_i     (op1_i),
  .ix_i      (ix_i),
  .iy_i      (iy_i),
  .valid_o   (valid_o),
  .ea_o      (ea_o),
  .ea_vld_o  (ea_vld_o),
  .tgt_o     (tgt_o),
  .tgt_vld_o (tgt_vld_o)
);

// File: tb/opnd_ea_gen_tb_top.sv
module opnd_ea_gen_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 14;
  localparam int  WDOG = 5000;

  typedef struct packed {
    logic [2:0]  am;
    logic        pfx;
    logic        ysel;
    logic [7:0]  op0;
    logic [7:0]  op1;
    logic [7:0]  op2;
    logic [15:0] pc;
    logic [15:0] ix;
    logic [15:0] iy;
    logic [15:0] ea;
    logic        eav;
    logic [15:0] tgt;
    logic        tgv;
  } vec_t;

  // am pfx ysel op0 op1 op2 pc ix iy | ea eav tgt tgv
  localparam vec_t VEC [NV] = '{
    '{3'd2, 1'b0, 1'b0, 8'h5A, 8'h00, 8'h00, 16'h1000, 16'h2000, 16'h3000, 16'h005A, 1'b1, 16'h0000, 1'b0}, // R1
    '{3'd3, 1'b0, 1'b0, 8'h12, 8'h34, 8'h00, 16'h1000, 16'h2000, 16'h3000, 16'h1234, 1'b1, 16'h0000, 1'b0}, // R2
    '{3'd4, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00, 16'h1000, 16'h2000, 16'h3000, 16'h20FF, 1'b1, 16'h0000, 1'b0}, // R3
    '{3'd4, 1'b1, 1'b1, 8'h80, 8'h00, 8'h00, 16'h1000, 16'h2000, 16'h3000, 16'h3080, 1'b1, 16'h0000, 1'b0}, // R4
    '{3'd5, 1'b0, 1'b0, 8'h10, 8'h00, 8'h00, 16'h1000, 16'h2000, 16'h3000, 16'h0000, 1'b0, 16'h1012, 1'b1}, // R5
    '{3'd5, 1'b0, 1'b0, 8'h80, 8'h00, 8'h00, 16'h1000, 16'h2000, 16'h3000, 16'h0000, 1'b0, 16'h0F82, 1'b1}, // R5
    '{3'd6, 1'b0, 1'b0, 8'h40, 8'hFF, 8'hFE, 16'h2000, 16'h2000, 16'h3000, 16'h0040, 1'b1, 16'h2002, 1'b1}, // R6
    '{3'd7, 1'b1, 1'b1, 8'h10, 8'h0F, 8'h05, 16'h2000, 16'h2000, 16'h4000, 16'h4010, 1'b1, 16'h200A, 1'b1}, // R6 R7
    '{3'd4, 1'b0, 1'b0, 8'h20, 8'h00, 8'h00, 16'h1000, 16'hFFF0, 16'h3000, 16'h0010, 1'b1, 16'h0000, 1'b0}, // R8
    '{3'd5, 1'b0, 1'b0, 8'h7F, 8'h00, 8'h00, 16'hFFFE, 16'h2000, 16'h3000, 16'h0000, 1'b0, 16'h007F, 1'b1}, // R8
    '{3'd0, 1'b0, 1'b0, 8'h55, 8'h66, 8'h77, 16'h1000, 16'h2000, 16'h3000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R9
    '{3'd1, 1'b1, 1'b0, 8'h12, 8'h34, 8'h00, 16'h1000, 16'h2000, 16'h3000, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R9
    '{3'd5, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 16'h1000, 16'h2000, 16'h3000, 16'h0000, 1'b0, 16'h1003, 1'b1}, // R7
    '{3'd7, 1'b0, 1'b0, 8'h01, 8'hAA, 8'h7F, 16'h3000, 16'h0100, 16'h3000, 16'h0101, 1'b1, 16'h3083, 1'b1}  // R6
  };

  localparam string TAG [NV] = '{"R1", "R2", "R3", "R4", "R5", "R5", "R6", "R6/R7",
                                 "R8", "R8", "R9", "R9", "R7", "R6"};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  amode_i = '0;
  logic        pfx_i = 1'b0;
  logic        idx_y_i = 1'b0;
  logic [7:0]  op0_i = '0, op1_i = '0, op2_i = '0;
  logic [15:0] pc_i = '0, ix_i = '0, iy_i = '0;
  logic        valid_o, ea_vld_o, tgt_vld_o;
  logic [15:0] ea_o, tgt_o;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  opnd_ea_gen dut_i (
    .clk_i, .rst_ni, .valid_i, .amode_i, .pfx_i, .idx_y_i,
    .op0_i, .op1_i, .op2_i, .pc_i, .ix_i, .iy_i,
    .valid_o, .ea_o, .ea_vld_o, .tgt_o, .tgt_vld_o
  );

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    valid_i = 1'b1;
    amode_i = v.am;  pfx_i = v.pfx; idx_y_i = v.ysel;
    op0_i = v.op0;   op1_i = v.op1; op2_i = v.op2;
    pc_i = v.pc;     ix_i = v.ix;   iy_i = v.iy;
  endtask

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk_i);
    check("R11", "valid_o", 16'(valid_o), 16'h0);
    check("R11", "ea_o", ea_o, 16'h0);
    check("R11", "tgt_o", tgt_o, 16'h0);
    check("R11", "flags", {14'h0, ea_vld_o, tgt_vld_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // vector stream, back to back: result due one edge after capture
    apply(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      check(TAG[i], "valid_o", 16'(valid_o), 16'h1);
      check(TAG[i], "ea_o", ea_o, VEC[i].ea);
      check(TAG[i], "ea_vld_o", 16'(ea_vld_o), 16'(VEC[i].eav));
      check(TAG[i], "tgt_o", tgt_o, VEC[i].tgt);
      check(TAG[i], "tgt_vld_o", 16'(tgt_vld_o), 16'(VEC[i].tgv));
      if (i + 1 < NV) apply(VEC[i + 1]);
    end

    // R10: strobe low, new inputs ignored, last result held
    valid_i = 1'b0;
    amode_i = 3'd3; op0_i = 8'hDE; op1_i = 8'hAD;
    @(negedge clk_i);
    check("R10", "valid_o low", 16'(valid_o), 16'h0);
    check("R10", "ea_o held", ea_o, 16'h0101);
    check("R10", "tgt_o held", tgt_o, 16'h3083);
    @(negedge clk_i);
    check("R10", "ea_o still held", ea_o, 16'h0101);

    // R10: single strobe after idle
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R2", "ea_o after idle", ea_o, 16'hDEAD);
    check("R10", "valid_o one pulse", 16'(valid_o), 16'h1);
    @(negedge clk_i);
    check("R10", "valid_o dropped", 16'(valid_o), 16'h0);

    // R11: asynchronous reset clears results
    rst_ni = 1'b0;
    #1;
    check("R11", "ea_o in reset", ea_o, 16'h0);
    check("R11", "flags in reset", {14'h0, ea_vld_o, tgt_vld_o}, 16'h0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < WDOG; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule